// File: doc/BRIEF.md
# Operation-Selected Integer ALU

This block is a purely combinational 32-bit arithmetic logic unit. Two operands and a 3-bit operation code enter. Every supported result is formed at the same time: the sum or difference, a bitwise exclusive-or, a signed-by-sign-bit comparison and a variable left shift. An output multiplexer then passes the one chosen by the code. The block also drives a carry flag and a zero flag.

A single ripple adder serves addition, subtraction and the comparison. For a difference, the adder takes the inverted second operand and a carry-in of one. The comparison looks only at the top bit of that difference.

The block has no clock and no registers, so there is no handshake. A caller that wants a result in a given cycle registers the outputs itself.

Top module: `alu_core`

## Requirements
- R1: With code 000, res_out equals (a_in + b_in) mod 2^32 and carry_out is bit 32 of the unsigned 33-bit sum.
- R2: With code 001, res_out equals (a_in - b_in) mod 2^32 and carry_out is the final carry of a_in + ~b_in + 1, which is 1 exactly when a_in >= b_in as unsigned numbers.
- R3: With code 010, each bit of res_out is 1 where the matching bits of a_in and b_in differ and 0 where they match.
- R4: With code 011, res_out is 32'h1 when bit 31 of (a_in - b_in) mod 2^32 is 1, and 32'h0 otherwise. Signed overflow is ignored, so a_in = 32'h80000000 with b_in = 1 gives 0.
- R5: With code 100, res_out is b_in shifted left by a_in[4:0] positions, with zeros filling the vacated low bits. a_in[31:5] has no effect on the result.
- R6: Codes 101, 110 and 111 give res_out = 0 and carry_out = 0.
- R7: zero_out is 1 exactly when the selected 32-bit res_out is all zeros.
- R8: carry_out is 0 for codes 010, 011 and 100.
- R9: The outputs follow the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand. For shifts, its low 5 bits give the shift amount. |
| b_in | input | 32 | Second operand. For shifts, this is the value that is shifted. |
| op_sel | input | 3 | Operation code, as listed in R1 to R6. |
| res_out | output | 32 | Selected result. |
| carry_out | output | 1 | Adder carry for add and subtract, otherwise 0. |
| zero_out | output | 1 | High when res_out is zero. |

## Verification
A fault in the shared adder's carry chain corrupts add, subtract and the comparison in the same cycle. It shows first on operand pairs that carry across many bit positions, such as all-ones plus one. A wrong inversion or carry-in for subtraction appears at once in the comparison result at the signed-overflow corner.

A broken shifter stage shows only for shift amounts that have that stage's bit set. The bench therefore sweeps every amount from 0 to 31. Because nothing is stored, every fault is visible in the same cycle as the input that exposes it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_XOR = 3'b010,
    OP_SLT = 3'b011,
    OP_SHL = 3'b100
  } alu_op_e;
endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;
  assign half = x_i ^ y_i;
  assign s_o  = half ^ c_i;
  assign c_o  = (x_i & y_i) | (half & c_i);
endmodule

// File: rtl/alu_ripple_addsub.sv
module alu_ripple_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         negate_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   chain;
  logic [W-1:0] y_eff;

  assign y_eff    = y_i ^ {W{negate_i}};
  assign chain[0] = negate_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    alu_fa_cell u_fa (
      .x_i (x_i[i]),
      .y_i (y_eff[i]),
      .c_i (chain[i]),
      .s_o (sum_o[i]),
      .c_o (chain[i+1])
    );
  end

  assign cout_o = chain[W];
endmodule

// File: rtl/alu_log_shifter.sv
module alu_log_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0]         val_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         val_o
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0] stg [0:STAGES];

  assign stg[0] = val_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {stg[k][W-1-STEP:0], {STEP{1'b0}}} : stg[k];
  end

  assign val_o = stg[STAGES];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    res_out,
  output logic            carry_out,
  output logic            zero_out
);
  localparam int SHW = $clog2(W);

  alu_op_e      op;
  logic         do_neg;
  logic [W-1:0] arith;
  logic         arith_c;
  logic [W-1:0] shifted;
  logic [W-1:0] xored;
  logic [W-1:0] less;

  assign op     = alu_op_e'(op_sel);
  assign do_neg = (op == OP_SUB) || (op == OP_SLT);

  alu_ripple_addsub #(.W(W)) u_addsub (
    .x_i      (a_in),
    .y_i      (b_in),
    .negate_i (do_neg),
    .sum_o    (arith),
    .cout_o   (arith_c)
  );

  alu_log_shifter #(.W(W)) u_shl (
    .val_i (b_in),
    .amt_i (a_in[SHW-1:0]),
    .val_o (shifted)
  );

  assign xored = a_in ^ b_in;
  assign less  = {{(W-1){1'b0}}, arith[W-1]};

  always_comb begin
    res_out   = '0;
    carry_out = 1'b0;
    case (op)
      OP_ADD:  begin res_out = arith; carry_out = arith_c; end
      OP_SUB:  begin res_out = arith; carry_out = arith_c; end
      OP_XOR:  res_out = xored;
      OP_SLT:  res_out = less;
      OP_SHL:  res_out = shifted;
      default: res_out = '0;
    endcase
  end

  assign zero_out = ~|res_out;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [2:0]   op_sel,
  input logic [W-1:0] res_out,
  input logic         carry_out,
  input logic         zero_out
);
  localparam int SHW = $clog2(W);

  logic [W:0]   wide_sum;
  logic [W-1:0] low_mask;

  assign wide_sum = {1'b0, a_in} + {1'b0, b_in};
  assign low_mask = (W'(1) << a_in[SHW-1:0]) - W'(1);

  always_comb begin
    // R1: add matches 33-bit sum
    a_r1_add: assert (op_sel != 3'b000 || {carry_out, res_out} == wide_sum);
    // R3: xor result
    a_r3_xor: assert (op_sel != 3'b010 || res_out == (a_in ^ b_in));
    // R4: comparison output is a single bit
    a_r4_slt_one_bit: assert (op_sel != 3'b011 || res_out[W-1:1] == '0);
    // R5: vacated low bits are zero
    a_r5_zero_fill: assert (op_sel != 3'b100 || (res_out & low_mask) == '0);
    // R6: unused codes give zero and zero flag
    a_r6_unused: assert (op_sel < 3'b101 || (res_out == '0 && !carry_out && zero_out));
    // R8: no carry outside add/sub
    a_r8_no_carry: assert (op_sel < 3'b010 || !carry_out);
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) i_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .op_sel    (op_sel),
  .res_out   (res_out),
  .carry_out (carry_out),
  .zero_out  (zero_out)
);

// File: tb/test_alu_core.sv
module test_alu_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [2:0]  op_sel = '0;
  logic [31:0] res_out;
  logic        carry_out;
  logic        zero_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core i_alu_core (
    .a_in      (a_in),
    .b_in      (b_in),
    .op_sel    (op_sel),
    .res_out   (res_out),
    .carry_out (carry_out),
    .zero_out  (zero_out)
  );

  // Behavioural reference: returns {carry, result}
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] op);
    longint unsigned ua = a;
    longint unsigned ub = b;
    longint unsigned t;
    logic [31:0] d;
    case (op)
      3'd0: begin t = ua + ub; return {t[32], t[31:0]}; end
      3'd1: return {(ua >= ub), 32'(ua - ub)};
      3'd2: return {1'b0, a ^ b};
      3'd3: begin d = a - b; return {1'b0, 31'd0, d[31]}; end
      3'd4: return {1'b0, b << a[4:0]};
      default: return 33'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare();
    logic [32:0] exp;
    exp = model(a_in, b_in, op_sel);
    checks++;
    if (res_out !== exp[31:0]) begin
      errors++;
      $display("FAIL %s result op=%0d a=%h b=%h actual=%h expected=%h",
               tag_of(op_sel), op_sel, a_in, b_in, res_out, exp[31:0]);
    end
    checks++;
    if (carry_out !== exp[32]) begin
      errors++;
      $display("FAIL %s/R8 carry op=%0d a=%h b=%h actual=%b expected=%b",
               tag_of(op_sel), op_sel, a_in, b_in, carry_out, exp[32]);
    end
    checks++;
    if (zero_out !== (exp[31:0] == 32'd0)) begin
      errors++;
      $display("FAIL R7 zero flag op=%0d actual=%b expected=%b",
               op_sel, zero_out, (exp[31:0] == 32'd0));
    end
  endtask

  // R9: inputs driven on falling edge, outputs compared one half period later
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(negedge clk);
    a_in = a; b_in = b; op_sel = op;
    @(posedge clk);
    #1;
    compare();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Idle state: all-zero inputs select add of zeros
    compare();

    // R1 corners: carry across full width
    apply(32'hFFFFFFFF, 32'h1, 3'd0);
    apply(32'h7FFFFFFF, 32'h1, 3'd0);
    apply(32'h12345678, 32'h0F0F0F0F, 3'd0);
    // R2 corners
    apply(32'h5, 32'h5, 3'd1);
    apply(32'h0, 32'h1, 3'd1);
    apply(32'h1, 32'h0, 3'd1);
    // R3
    apply(32'hAAAA5555, 32'hFFFF0000, 3'd2);
    apply(32'hDEADBEEF, 32'hDEADBEEF, 3'd2);
    // R4 overflow corner and plain cases
    apply(32'h80000000, 32'h1, 3'd3);
    apply(32'hFFFFFFFF, 32'h0, 3'd3);
    apply(32'h3, 32'h7, 3'd3);
    apply(32'h7, 32'h3, 3'd3);
    // R5: every amount, upper bits of a ignored
    for (int s = 0; s < 32; s++) apply(32'hFFFFFFE0 | 32'(s), 32'h8000_0001 ^ 32'(s*97), 3'd4);
    // R6: unused codes
    for (int c = 5; c < 8; c++) apply(32'hFFFFFFFF, 32'hFFFFFFFF, 3'(c));
    // Mixed random sweep over all codes
    for (int n = 0; n < 2000; n++) apply($urandom, $urandom, 3'($urandom_range(0, 7)));

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule